// File: doc/BRIEF.md
# Address-Strobe Read Sequencer

This block generates single read transfers for external devices that capture their address on a one-cycle address-valid strobe (ADV). It accepts one request at a time. It drives chip select and the strobe, presents the address for one or two cycles and asserts output enable after a programmable delay. It then samples the 16-bit read data and reports completion with a one-cycle done pulse. Three configuration inputs set the timing of each transfer, and they are sampled when the request is accepted. The first is a flag that keeps the address on the bus for one extra cycle after the strobe. The second is a 2-bit strobe-to-OE spacing. The third is a 4-bit count for the first segment, measured from chip select to OE.

Cycles of a transfer are numbered from 0, where cycle 0 is the first cycle with chip select asserted. The controller moves through these states:
- IDLE: ready for a request. Accepting a request leads to ADDR.
- ADDR: cycle 0. The strobe is asserted and the address is driven. With address hold set, the next state is AHOLD. Otherwise it is OE1 when the start cycle is 1, and WAIT in all other cases.
- AHOLD: the extra address cycle. The next state is OE1 when the start cycle is 2, and WAIT otherwise.
- WAIT: chip select only. The next state is OE1 when the next cycle is the start cycle.
- OE1 and OE2: output enable is asserted. OE1 always leads to OE2 and OE2 to DONE.
- DONE: the done pulse. The next state is IDLE.

Top module: `adv_read_seq`

## Requirements
- R1: After reset, bus_cs, bus_adv, bus_oe and done are 0, bus_addr is 0 and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only in IDLE, and req_valid has no effect while a transfer is in progress.
- R3: bus_cs is asserted from the cycle after acceptance (cycle 0). bus_adv is 1 in cycle 0 only.
- R4: bus_addr carries the accepted address in cycle 0 and is 0 outside the address phase.
- R5: When the address-hold flag is 1, bus_addr also carries the address in cycle 1, and OE does not start before cycle 2.
- R6: OE first asserts in cycle T. T is the largest of three values: the read-hold count, the strobe-to-OE spacing plus 1, and 2 when address hold is set or 1 when it is not.
- R7: bus_oe is asserted for exactly two cycles, T and T+1. bus_rdata is sampled at the end of cycle T+1.
- R8: bus_cs and bus_oe deassert together in cycle T+2. done is 1 for that cycle only, and rdata holds the sampled word from then until the next capture.
- R9: Configuration inputs are sampled at acceptance. Changes to them during a transfer do not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Read address |
| req_ready | output | 1 | Sequencer idle and able to accept |
| cfg_addr_hold | input | 1 | Keep the address one extra cycle after the strobe |
| cfg_adv_oe | input | AOE_W | Cycles between the strobe and OE |
| cfg_rd_hold | input | RH_W | Cycles from chip select to OE |
| bus_cs | output | 1 | Chip select, active high |
| bus_adv | output | 1 | Address-valid strobe, active high |
| bus_oe | output | 1 | Output enable, active high |
| bus_addr | output | ADDR_W | Address to the device |
| bus_rdata | input | DATA_W | Data from the device |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
The directed cases choose timing settings so that each term of the OE start rule wins in turn: the minimum of one cycle, the address-hold floor of two, the strobe spacing at its maximum, the read-hold count at its maximum, and a mixed case. A wrong maximum or an off-by-one therefore shows up as a shifted OE window. The bench drives the inverted data word in every cycle except the last OE cycle, so sampling in the wrong cycle returns the wrong data. Further cases pulse a request in the middle of a transfer and change the configuration after acceptance, to confirm that neither affects the transfer in progress. Random settings cover the remaining combinations.

// File: rtl/ars_pkg.sv
package ars_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_AHOLD = 3'd2,
        S_WAIT  = 3'd3,
        S_OE1   = 3'd4,
        S_OE2   = 3'd5,
        S_DONE  = 3'd6
    } ars_state_t;
endpackage

// File: rtl/ars_timing.sv
module ars_timing #(
    parameter int AOE_W = 2,
    parameter int RH_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic             addr_hold,
    input  logic [AOE_W-1:0] adv_oe,
    input  logic [RH_W-1:0]  rd_hold,
    output logic [CNT_W-1:0] oe_start
);
    logic [CNT_W-1:0] from_adv;
    logic [CNT_W-1:0] from_cs;
    logic [CNT_W-1:0] floor_v;
    logic [CNT_W-1:0] larger;

    always_comb begin
        from_adv = CNT_W'(adv_oe) + CNT_W'(1);
        from_cs  = CNT_W'(rd_hold);
        floor_v  = addr_hold ? CNT_W'(2) : CNT_W'(1);
        larger   = (from_adv > from_cs) ? from_adv : from_cs;
        oe_start = (larger > floor_v) ? larger : floor_v;
    end
endmodule

// File: rtl/ars_fsm.sv
module ars_fsm
    import ars_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             addr_hold,
    input  logic [CNT_W-1:0] oe_start,
    output logic             accept,
    output logic             ready,
    output logic             cs,
    output logic             adv,
    output logic             oe,
    output logic             addr_phase,
    output logic             capture,
    output logic             done
);
    ars_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] start_q;
    logic             hold_q;
    logic [CNT_W-1:0] cnt_nx;

    assign accept = (state == S_IDLE) && req_valid;
    assign cnt_nx = cnt + CNT_W'(1);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_ADDR;
            S_ADDR: begin
                if (hold_q)                 state_nx = S_AHOLD;
                else if (cnt_nx == start_q) state_nx = S_OE1;
                else                        state_nx = S_WAIT;
            end
            S_AHOLD: state_nx = (cnt_nx == start_q) ? S_OE1 : S_WAIT;
            S_WAIT:  if (cnt_nx == start_q) state_nx = S_OE1;
            S_OE1:   state_nx = S_OE2;
            S_OE2:   state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            start_q <= '0;
            hold_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cnt     <= '0;
                start_q <= oe_start;
                hold_q  <= addr_hold;
            end else if (state == S_ADDR || state == S_AHOLD || state == S_WAIT) begin
                cnt <= cnt_nx;
            end
        end
    end

    always_comb begin
        ready      = 1'b0;
        cs         = 1'b0;
        adv        = 1'b0;
        oe         = 1'b0;
        addr_phase = 1'b0;
        capture    = 1'b0;
        done       = 1'b0;
        unique case (state)
            S_IDLE:  ready = 1'b1;
            S_ADDR:  begin cs = 1'b1; adv = 1'b1; addr_phase = 1'b1; end
            S_AHOLD: begin cs = 1'b1; addr_phase = 1'b1; end
            S_WAIT:  cs = 1'b1;
            S_OE1:   begin cs = 1'b1; oe = 1'b1; end
            S_OE2:   begin cs = 1'b1; oe = 1'b1; capture = 1'b1; end
            S_DONE:  done = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    a_r3_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);
    a_r3_adv_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> cs);
    a_r5_no_oe_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> !oe);
    a_r7_oe_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |=> oe);
    a_r8_cs_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> (!cs && done));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cs);
endmodule

// File: rtl/ars_datapath.sv
module ars_datapath #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              addr_phase,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rdata  <= '0;
        end else begin
            if (accept)  addr_q <= req_addr;
            if (capture) rdata  <= bus_rdata;
        end
    end

    assign bus_addr = addr_phase ? addr_q : '0;
endmodule

// File: rtl/adv_read_seq.sv
module adv_read_seq #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int AOE_W  = 2,
    parameter int RH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              cfg_addr_hold,
    input  logic [AOE_W-1:0]  cfg_adv_oe,
    input  logic [RH_W-1:0]   cfg_rd_hold,
    output logic              bus_cs,
    output logic              bus_adv,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = ((RH_W > AOE_W) ? RH_W : AOE_W) + 1;

    logic [CNT_W-1:0] oe_start;
    logic             accept;
    logic             addr_phase;
    logic             capture;

    ars_timing #(.AOE_W(AOE_W), .RH_W(RH_W), .CNT_W(CNT_W)) u_timing (
        .addr_hold (cfg_addr_hold),
        .adv_oe    (cfg_adv_oe),
        .rd_hold   (cfg_rd_hold),
        .oe_start  (oe_start)
    );

    ars_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .addr_hold  (cfg_addr_hold),
        .oe_start   (oe_start),
        .accept     (accept),
        .ready      (req_ready),
        .cs         (bus_cs),
        .adv        (bus_adv),
        .oe         (bus_oe),
        .addr_phase (addr_phase),
        .capture    (capture),
        .done       (done)
    );

    ars_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .addr_phase (addr_phase),
        .capture    (capture),
        .bus_rdata  (bus_rdata),
        .bus_addr   (bus_addr),
        .rdata      (rdata)
    );
endmodule

// File: tb/adv_read_seq_tb.sv
module adv_read_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [8:0]  req_addr = '0;
    logic        req_ready;
    logic        cfg_addr_hold = 1'b0;
    logic [1:0]  cfg_adv_oe = '0;
    logic [3:0]  cfg_rd_hold = '0;
    logic        bus_cs, bus_adv, bus_oe, done;
    logic [8:0]  bus_addr;
    logic [15:0] bus_rdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adv_read_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .cfg_addr_hold(cfg_addr_hold),
        .cfg_adv_oe(cfg_adv_oe), .cfg_rd_hold(cfg_rd_hold),
        .bus_cs(bus_cs), .bus_adv(bus_adv), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .done(done), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_start(input logic h, input logic [1:0] a, input logic [3:0] r);
        int t;
        t = int'(r);
        if (int'(a) + 1 > t) t = int'(a) + 1;
        if (h && t < 2) t = 2;
        return t;
    endfunction

    task automatic do_read(input logic [8:0] addr, input logic h, input logic [1:0] a,
                           input logic [3:0] r, input logic [15:0] data, input bit poke);
        int t;
        t = exp_start(h, a, r);
        @(negedge clk);
        chk("R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = addr;
        cfg_addr_hold = h; cfg_adv_oe = a; cfg_rd_hold = r;
        bus_rdata = ~data;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: disturb configuration after acceptance
        cfg_addr_hold = ~h; cfg_adv_oe = ~a; cfg_rd_hold = ~r;
        for (int k = 0; k <= t + 2; k++) begin
            bus_rdata = (k == t + 1) ? data : ~data;
            if (poke && k == 1) begin req_valid = 1'b1; req_addr = ~addr; end
            if (poke && k == 2) req_valid = 1'b0;
            chk("R3 R9 cs", bus_cs, (k <= t + 1) ? 1 : 0);
            chk("R3 adv", bus_adv, (k == 0) ? 1 : 0);
            chk("R6 R7 R5 oe", bus_oe, (k == t || k == t + 1) ? 1 : 0);
            chk("R4 R5 addr", bus_addr, (k == 0 || (h && k == 1)) ? addr : 9'd0);
            chk("R2 ready busy", req_ready, 0);
            chk("R8 done", done, (k == t + 2) ? 1 : 0);
            if (k == t + 2) chk("R7 R8 rdata", rdata, data);
            @(negedge clk);
        end
        bus_rdata = ~data;
        chk("R8 idle cs", bus_cs, 0);
        chk("R8 done low", done, 0);
        chk("R8 rdata held", rdata, data);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk("R2 busy request ignored", bus_cs, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 cs", bus_cs, 0);
        chk("R1 adv", bus_adv, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 done", done, 0);
        chk("R1 addr", bus_addr, 0);
        chk("R1 ready", req_ready, 1);
        rst_n = 1'b1;
        do_read(9'h0A5, 1'b0, 2'd0, 4'd0,  16'h1234, 1'b0); // R6 minimum
        do_read(9'h15A, 1'b1, 2'd0, 4'd0,  16'hBEEF, 1'b0); // R5 floor
        do_read(9'h1FF, 1'b0, 2'd3, 4'd1,  16'h0F0F, 1'b0); // R6 adv spacing
        do_read(9'h001, 1'b0, 2'd1, 4'd15, 16'hA5A5, 1'b0); // R6 read hold
        do_read(9'h123, 1'b1, 2'd3, 4'd2,  16'h5555, 1'b0); // mixed
        do_read(9'h0C3, 1'b0, 2'd2, 4'd5,  16'h8001, 1'b1); // R2 busy poke
        for (int i = 0; i < 40; i++) begin
            do_read(9'($urandom), 1'($urandom), 2'($urandom), 4'($urandom),
                    16'($urandom), 1'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule